// File: doc/BRIEF.md
# Dual-Timer Output Combiner

This block joins the output levels of an 8-bit timer and a 16-bit timer into a single transmit output. A small control register picks one of four Boolean merges of the two levels. The merged result is registered, so it changes one clock after its inputs change.

The same register also sets how the 16-bit timer's pin is driven. The pin can run in normal or ping-pong submode, or it can be held low or held high. In normal and ping-pong submode the pin first holds an idle level, which is the inverse of an initial-level bit. When the 16-bit timer reports that it is counting, the pin starts to follow the timer output.

A full reset clears the whole register. A stop-recovery pulse clears the submode and the initial-level bit but keeps the merge selection. The counters themselves are outside the block and arrive as plain inputs. For ping-pong, the block only records whether it is enabled. It does not schedule the alternation.

Top module: `tmr_out_merge`

## Requirements
- R1: The merge code in control bits [4:3] selects the combined output: 00 gives t8 AND t16, 01 gives OR, 10 gives NOR, 11 gives NAND.
- R2: The combined output is registered. It shows the merge of the inputs present at the previous rising clock edge.
- R3: Submode bits [2:1] equal to 10 hold the 16-bit pin low, and equal to 11 hold it high, whatever the timer inputs are.
- R4: After a write with submode 00 or 01, the 16-bit pin shows the inverse of control bit [0] until the counting flag is sampled high.
- R5: Once the counting flag has been sampled high in submode 00 or 01, the pin follows the 16-bit timer level one clock later. This continues even if counting stops, until the next control write.
- R6: The ping-pong status output becomes 1 one clock after a write with submode 01. It becomes 0 one clock after a write with submode 00, 10 or 11.
- R7: A stop-recovery pulse with no write in the same cycle keeps the merge code. It clears the submode, the initial-level bit and the ping-pong status, and it re-arms the idle level.
- R8: A synchronous active-low reset clears all control fields. After reset the combined output is 0, the pin is 1 (idle level with initial-level bit 0), and ping-pong status is 0. A write in the same cycle as a stop-recovery pulse takes priority over the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_rcv | input | 1 | Stop-recovery pulse |
| t8_lvl | input | 1 | 8-bit timer output level |
| t16_lvl | input | 1 | 16-bit timer output level |
| t16_run | input | 1 | 16-bit timer is counting |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 5 | Control data: [4:3] merge code, [2:1] submode, [0] initial-level bit |
| merged_out | output | 1 | Registered combined output |
| t16_pin | output | 1 | Driven 16-bit timer pin level |
| pingpong_on | output | 1 | Ping-pong submode enabled |

## Verification
The merge is tried with all four timer-level pairs under each of the four merge codes. Because each code gives a different truth table, a swapped code or a missing inversion changes at least one of the sixteen results.

The pin is tested with the forced levels set opposite to the timer level. In idle it is tested with the timer level set opposite to the expected idle value. Both ways, a leak of the timer level shows at once.

The stop-recovery test sets NOR and a forced-low pin before the pulse. After the pulse, a kept merge code and a cleared submode give outputs that differ from a full clear.

// File: rtl/tmr_merge_pkg.sv
// Shared widths and field types for the dual-timer output combiner.
package tmr_merge_pkg;
    localparam int SEL_W  = 2;
    localparam int MODE_W = 2;
    localparam int CFG_W  = SEL_W + MODE_W + 1;

    typedef enum logic [SEL_W-1:0] {
        MRG_AND  = 2'b00,
        MRG_OR   = 2'b01,
        MRG_NOR  = 2'b10,
        MRG_NAND = 2'b11
    } merge_op_e;

    typedef enum logic [MODE_W-1:0] {
        DRV_NORMAL   = 2'b00,
        DRV_PINGPONG = 2'b01,
        DRV_LOW      = 2'b10,
        DRV_HIGH     = 2'b11
    } drive_e;

    typedef struct packed {
        merge_op_e op;
        drive_e    drv;
        logic      init;
    } cfg_t;
endpackage

// File: rtl/tmr_merge_ctl.sv
// Control register. Holds the merge code, the submode and the initial-level bit.
// Tracks the idle (pre-count) state and the ping-pong enable.
// Assumes: rst_n is synchronous; a write outranks a stop-recovery pulse.
module tmr_merge_ctl
    import tmr_merge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_rcv,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             t16_run,
    output cfg_t             cfg_q,
    output logic             waiting_q,
    output logic             pp_q
);
    cfg_t wr_cfg;
    assign wr_cfg = cfg_t'(cfg_wdata);

    // Update the control fields on reset, on a write or on stop recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{op: MRG_AND, drv: DRV_NORMAL, init: 1'b0};
            pp_q  <= 1'b0;
        end else if (cfg_we) begin
            cfg_q <= wr_cfg;
            pp_q  <= (wr_cfg.drv == DRV_PINGPONG);
        end else if (stop_rcv) begin
            cfg_q.drv  <= DRV_NORMAL;
            cfg_q.init <= 1'b0;
            pp_q       <= 1'b0;
        end
    end

    // Idle flag: armed by reset, stop or a normal/ping-pong write; cleared once counting is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b1;
        end else if (cfg_we) begin
            waiting_q <= (wr_cfg.drv == DRV_NORMAL) || (wr_cfg.drv == DRV_PINGPONG);
        end else if (stop_rcv) begin
            waiting_q <= 1'b1;
        end else if (t16_run) begin
            waiting_q <= 1'b0;
        end
    end

    // R7
    stop_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_rcv && !cfg_we) |=> (cfg_q.op == $past(cfg_q.op)) && (cfg_q.drv == DRV_NORMAL));
    // R6
    pp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[2:1] == 2'b01) |=> pp_q);
    // R6
    pp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[2:1] != 2'b01) |=> !pp_q);
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0) && !pp_q);
endmodule

// File: rtl/tmr_merge_logic.sv
// Boolean merge of the two timer levels, registered.
// Assumes: sel is stable from the control register.
module tmr_merge_logic
    import tmr_merge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  merge_op_e sel,
    input  logic      a_lvl,
    input  logic      b_lvl,
    output logic      out_q
);
    logic mrg_d;

    // Pick the merge function from the code.
    always_comb begin
        case (sel)
            MRG_AND:  mrg_d = a_lvl & b_lvl;
            MRG_OR:   mrg_d = a_lvl | b_lvl;
            MRG_NOR:  mrg_d = ~(a_lvl | b_lvl);
            default:  mrg_d = ~(a_lvl & b_lvl);
        endcase
    end

    // Register the merged level.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= mrg_d;
    end

    // R1 R2
    and_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == MRG_AND && a_lvl && b_lvl) |=> out_q);
    // R1 R2
    nor_any_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == MRG_NOR && (a_lvl || b_lvl)) |=> !out_q);
endmodule

// File: rtl/tmr_merge_pin.sv
// Drives the 16-bit timer pin: forced levels, the idle level before counting, or the timer level.
// Assumes: waiting comes from the control block and is cleared after counting is seen.
module tmr_merge_pin
    import tmr_merge_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cfg_t   cfg,
    input  logic   waiting,
    input  logic   t16_lvl,
    input  logic   t16_run,
    output logic   pin_q
);
    logic pin_d;

    // Choose the pin level for the submode.
    always_comb begin
        case (cfg.drv)
            DRV_LOW:  pin_d = 1'b0;
            DRV_HIGH: pin_d = 1'b1;
            default:  pin_d = (waiting && !t16_run) ? ~cfg.init : t16_lvl;
        endcase
    end

    // Register the pin level.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= pin_d;
    end

    // R3
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.drv == DRV_LOW) |=> !pin_q);
    // R3
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.drv == DRV_HIGH) |=> pin_q);
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.drv[1] == 1'b0 && waiting && !t16_run) |=> (pin_q == !$past(cfg.init)));
endmodule

// File: rtl/tmr_out_merge.sv
// Top of the dual-timer output combiner: control register, merge path, pin driver.
// Assumes: timer levels and the counting flag are synchronous to clk.
module tmr_out_merge
    import tmr_merge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_rcv,
    input  logic             t8_lvl,
    input  logic             t16_lvl,
    input  logic             t16_run,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             merged_out,
    output logic             t16_pin,
    output logic             pingpong_on
);
    cfg_t cfg_q;
    logic waiting_q;

    tmr_merge_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .stop_rcv(stop_rcv), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .t16_run(t16_run),
        .cfg_q(cfg_q), .waiting_q(waiting_q), .pp_q(pingpong_on)
    );

    tmr_merge_logic u_logic (
        .clk(clk), .rst_n(rst_n), .sel(cfg_q.op),
        .a_lvl(t8_lvl), .b_lvl(t16_lvl), .out_q(merged_out)
    );

    tmr_merge_pin u_pin (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .waiting(waiting_q),
        .t16_lvl(t16_lvl), .t16_run(t16_run), .pin_q(t16_pin)
    );

    // R5
    follow_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !stop_rcv && cfg_q.drv[1] == 1'b0 && !waiting_q) |=> (t16_pin == $past(t16_lvl)));
endmodule

// File: tb/tmr_out_merge_test.sv
// Self-checking bench: table-driven merge vectors, then directed submode, stop and reset tests.
module tmr_out_merge_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_rcv = 1'b0;
    logic t8_lvl = 1'b0;
    logic t16_lvl = 1'b0;
    logic t16_run = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic merged_out, t16_pin, pingpong_on;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_out_merge uut (
        .clk(clk), .rst_n(rst_n), .stop_rcv(stop_rcv), .t8_lvl(t8_lvl),
        .t16_lvl(t16_lvl), .t16_run(t16_run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .merged_out(merged_out), .t16_pin(t16_pin), .pingpong_on(pingpong_on)
    );

    // Entry: {merge code, t8, t16, expected}
    localparam logic [4:0] VEC [16] = '{
        5'b00_00_0, 5'b00_01_0, 5'b00_10_0, 5'b00_11_1,
        5'b01_00_0, 5'b01_01_1, 5'b01_10_1, 5'b01_11_1,
        5'b10_00_1, 5'b10_01_0, 5'b10_10_0, 5'b10_11_0,
        5'b11_00_1, 5'b11_01_1, 5'b11_10_1, 5'b11_11_0
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [1:0] mode, input logic init);
        cfg_wdata = {sel, mode, init};
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2;
        step(); step();
        // R8 reset state
        check("R8 merged", merged_out, 1'b0);
        check("R8 pin", t16_pin, 1'b1);
        check("R8 pp", pingpong_on, 1'b0);
        rst_n = 1'b1;
        step();

        // R1 R2 table of merge vectors
        for (int i = 0; i < 16; i++) begin
            wr(VEC[i][4:3], 2'b00, 1'b0);
            t8_lvl = VEC[i][2];
            t16_lvl = VEC[i][1];
            step();
            check("R1", merged_out, VEC[i][0]);
        end

        // R2 output holds until the next edge after an input change
        wr(2'b00, 2'b00, 1'b0);
        t8_lvl = 1'b1; t16_lvl = 1'b1;
        step();
        check("R2 settled", merged_out, 1'b1);
        @(negedge clk);
        t8_lvl = 1'b0;
        #1;
        check("R2 before edge", merged_out, 1'b1);
        step();
        check("R2 after edge", merged_out, 1'b0);

        // R3 forced levels oppose the timer level
        t16_lvl = 1'b1; t16_run = 1'b1;
        wr(2'b00, 2'b10, 1'b0);
        step();
        check("R3 low", t16_pin, 1'b0);
        t16_lvl = 1'b0;
        wr(2'b00, 2'b11, 1'b0);
        step();
        check("R3 high", t16_pin, 1'b1);

        // R4 idle level is ~init; R5 then follow the timer
        t16_run = 1'b0; t16_lvl = 1'b1;
        wr(2'b00, 2'b00, 1'b1);
        step();
        check("R4 idle", t16_pin, 1'b0);
        step();
        check("R4 idle held", t16_pin, 1'b0);
        t16_run = 1'b1;
        step();
        check("R5 follow", t16_pin, 1'b1);
        t16_run = 1'b0;
        step(); step();
        check("R5 keeps following", t16_pin, 1'b1);
        t16_lvl = 1'b0;
        step();
        check("R5 tracks low", t16_pin, 1'b0);

        // R6 ping-pong status
        wr(2'b00, 2'b01, 1'b0);
        check("R6 set", pingpong_on, 1'b1);
        wr(2'b00, 2'b00, 1'b0);
        check("R6 clear by 00", pingpong_on, 1'b0);
        wr(2'b00, 2'b01, 1'b0);
        wr(2'b00, 2'b11, 1'b0);
        check("R6 clear by 11", pingpong_on, 1'b0);

        // R7 stop recovery keeps NOR, releases forced low
        t8_lvl = 1'b0; t16_lvl = 1'b0; t16_run = 1'b0;
        wr(2'b10, 2'b10, 1'b1);
        step();
        check("R7 before stop pin", t16_pin, 1'b0);
        stop_rcv = 1'b1;
        step();
        stop_rcv = 1'b0;
        step();
        check("R7 sel kept", merged_out, 1'b1);
        check("R7 idle pin", t16_pin, 1'b1);
        check("R7 pp", pingpong_on, 1'b0);

        // R8 write outranks stop in the same cycle
        cfg_wdata = {2'b00, 2'b10, 1'b0};
        cfg_we = 1'b1; stop_rcv = 1'b1;
        step();
        cfg_we = 1'b0; stop_rcv = 1'b0;
        step();
        check("R8 write wins", t16_pin, 1'b0);

        // R8 reset clears the merge code
        wr(2'b11, 2'b00, 1'b0);
        t8_lvl = 1'b1; t16_lvl = 1'b1;
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check("R8 sel cleared", merged_out, 1'b1);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule